// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack side of subroutine entry and exit for a small 8-bit processor core. It handles eight operations: direct call, table call, return, return from interrupt, and push or pop of either the status byte or a 16-bit register pair. Each operation runs against a byte-wide data memory, with one access per cycle. The block owns the 16-bit stack pointer. It hands back a new program counter, a restored status byte or a popped pair, and each comes with a one-cycle load strobe. Decode lies outside the block: a decoder presents one request with its operands, and the block stays busy for a fixed number of cycles per operation.

Words sit on the stack with the high byte at the higher address. Pushes move the stack pointer downward. Pointer arithmetic wraps modulo 65536. A table call gets its target from an even-aligned two-byte vector in low memory. A return from interrupt also restores the status byte and clears a flag that marks non-maskable interrupt servicing. An external interrupt-entry pulse sets that flag.

Top module: `callret_seq`

## Requirements
- R1: After reset the stack pointer equals parameter SP_INIT (default 0000h), `done`, `busy`, `mem_rd`, `mem_wr`, all load strobes and `nmi_flag` are low.
- R2: A request (`req_valid` high at a rising edge) is accepted only while `busy` is low; a request raised while busy has no effect on the accesses, outputs or cycle count of the operation in progress, and the block is idle in the cycle after `done`.
- R3: `req_op` encodes 0 direct call, 1 table call, 2 return, 3 return-from-interrupt, 4 push status, 5 push pair, 6 pop status, 7 pop pair; these take 6, 8, 6, 8, 2, 4, 4 and 6 cycles. Step k of an operation is the k-th cycle after the accepting edge (k from 0), and `done` is high for exactly one cycle, in the last step.
- R4: At most one of `mem_rd`/`mem_wr` is high in a cycle, and only while busy; read data is taken from `mem_rdata` in the cycle after the read strobe.
- R5: A direct call writes the high byte of `pc_in`+3 to SP-1 in step 0 and the low byte to SP-2 in step 1, then loads PC with `req_target` and SP with SP-2.
- R6: A table call pushes `pc_in`+1 the same way, reads the vector at 0040h + 2*`req_index` in step 2 (PC low byte) and at that address +1 in step 3 (PC high byte); vector reads stay within 0040h..007Fh. SP ends at SP-2.
- R7: A return reads SP in step 0 (PC low) and SP+1 in step 1 (PC high), and SP ends at SP+2.
- R8: A return from interrupt reads SP, SP+1 and SP+2 in steps 0..2 (PC low, PC high, status), ends with SP+3 and clears `nmi_flag`; a `nmi_enter` pulse sets `nmi_flag`.
- R9: Push status writes `psw_in` at SP-1 in step 0 and leaves SP-1; pop status reads SP in step 0 and leaves SP+1 with the byte on `psw_out`.
- R10: Push pair writes the high byte of `req_pair` at SP-1 (step 0) and the low byte at SP-2 (step 1), ending at SP-2; pop pair reads SP (low) then SP+1 (high) and ends at SP+2.
- R11: All stack addresses and the stack pointer wrap modulo 2^16.
- R12: In the `done` cycle the new SP, PC, status and pair are on the outputs; `pc_load` is high with `done` for ops 0..3, `psw_load` for ops 3 and 6, `pair_load` for op 7, and the strobes are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code |
| req_target | input | 16 | Direct call target |
| req_index | input | 5 | Table call vector index |
| req_pair | input | 16 | Register pair to push |
| pc_in | input | 16 | Address of the current instruction |
| psw_in | input | 8 | Status byte to push |
| nmi_enter | input | 1 | Sets the non-maskable servicing flag |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | PC load strobe |
| sp_out | output | 16 | Stack pointer |
| psw_out | output | 8 | Restored status byte |
| psw_load | output | 1 | Status load strobe |
| pair_out | output | 16 | Popped register pair |
| pair_load | output | 1 | Pair load strobe |
| nmi_flag | output | 1 | Non-maskable servicing flag |

## Verification
Each memory access is due in a fixed step after the accepting edge: pushed bytes in steps 0 and 1, stack reads from step 0, and vector reads in steps 2 and 3. The stack pointer, PC, status and pair results appear together with `done` in step N-1, where N is the operation's cycle budget. The bench's reference model builds the full per-step access list and the final results from its own copy of memory before the request. It then compares strobes, address, write data and `done` at the falling edge of every step, and the results at step N-1. After `done` it checks one more cycle for idleness, and it raises a second request during step 1 to confirm the running operation keeps its timing.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int AW    = 16;
  localparam int BW    = 8;
  localparam int IDX_W = 5;
  localparam int STEP_W = 4;
  localparam logic [AW-1:0] VEC_BASE = 16'h0040;

  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_CALLT = 3'd1,
    OP_RET   = 3'd2,
    OP_RETI  = 3'd3,
    OP_PUSHF = 3'd4,
    OP_PUSHP = 3'd5,
    OP_POPF  = 3'd6,
    OP_POPP  = 3'd7
  } cr_op_e;

  // Cycle budget of each operation.
  function automatic logic [STEP_W-1:0] op_cycles(cr_op_e op);
    case (op)
      OP_CALL:  return 4'd6;
      OP_CALLT: return 4'd8;
      OP_RET:   return 4'd6;
      OP_RETI:  return 4'd8;
      OP_PUSHF: return 4'd2;
      OP_PUSHP: return 4'd4;
      OP_POPF:  return 4'd4;
      default:  return 4'd6;
    endcase
  endfunction

  // Number of stack reads a popping operation issues.
  function automatic logic [STEP_W-1:0] pop_reads(cr_op_e op);
    case (op)
      OP_RET, OP_POPP: return 4'd2;
      OP_RETI:         return 4'd3;
      OP_POPF:         return 4'd1;
      default:         return 4'd0;
    endcase
  endfunction

  // Stack pointer after the operation, modulo 2^16.
  function automatic logic [AW-1:0] sp_after(cr_op_e op, logic [AW-1:0] sp);
    case (op)
      OP_CALL, OP_CALLT, OP_PUSHP: return sp - 16'd2;
      OP_PUSHF:                    return sp - 16'd1;
      OP_POPF:                     return sp + 16'd1;
      OP_RETI:                     return sp + 16'd3;
      default:                     return sp + 16'd2;
    endcase
  endfunction

  function automatic logic [AW-1:0] vector_addr(logic [IDX_W-1:0] idx);
    return VEC_BASE | {{(AW-IDX_W-1){1'b0}}, idx, 1'b0};
  endfunction

  function automatic logic [AW-1:0] return_pc(cr_op_e op, logic [AW-1:0] pc);
    return pc + ((op == OP_CALL) ? 16'd3 : 16'd1);
  endfunction
endpackage

// File: rtl/cr_sched.sv
module cr_sched
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] n_in,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              commit,
  output logic              done
);
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] n_q;

  assign busy   = busy_q;
  assign step   = step_q;
  assign commit = busy_q && (step_q == n_q - 4'd2);
  assign done   = busy_q && (step_q == n_q - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      n_q    <= 4'd2;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      step_q <= '0;
      n_q    <= n_in;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      step_q <= step_q + 4'd1;
    end
  end

  // R3: done lasts a single cycle and ends the operation
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R3: the step counter never runs past the budget
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step_q < n_q);
  // R3: commit is followed by done
  a_r3_commit_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);
endmodule

// File: rtl/cr_access.sv
module cr_access
  import cr_pkg::*;
(
  input  logic              busy,
  input  cr_op_e            op,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     word,
  input  logic [BW-1:0]     psw,
  input  logic [AW-1:0]     vec,
  output logic              rd,
  output logic              wr,
  output logic [AW-1:0]     addr,
  output logic [BW-1:0]     wdata,
  output logic [1:0]        slot
);
  always_comb begin
    rd    = 1'b0;
    wr    = 1'b0;
    addr  = sp;
    wdata = '0;
    slot  = 2'd0;
    if (busy) begin
      case (op)
        OP_CALL, OP_CALLT, OP_PUSHP: begin
          if (step == 4'd0) begin
            wr = 1'b1; addr = sp - 16'd1; wdata = word[15:8];
          end else if (step == 4'd1) begin
            wr = 1'b1; addr = sp - 16'd2; wdata = word[7:0];
          end else if (op == OP_CALLT && step == 4'd2) begin
            rd = 1'b1; addr = vec; slot = 2'd0;
          end else if (op == OP_CALLT && step == 4'd3) begin
            rd = 1'b1; addr = vec + 16'd1; slot = 2'd1;
          end
        end
        OP_PUSHF: begin
          if (step == 4'd0) begin
            wr = 1'b1; addr = sp - 16'd1; wdata = psw;
          end
        end
        default: begin
          if (step < pop_reads(op)) begin
            rd   = 1'b1;
            addr = sp + {{(AW-STEP_W){1'b0}}, step};
            slot = step[1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cr_rdbuf.sv
module cr_rdbuf
  import cr_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd,
  input  logic [1:0]              slot,
  input  logic [BW-1:0]           rdata,
  output logic [SLOTS-1:0][BW-1:0] bytes
);
  logic       pend_q;
  logic [1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      slot_q <= 2'd0;
    end else begin
      pend_q <= rd;
      slot_q <= slot;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             bytes[g] <= '0;
      else if (pend_q && slot_q == 2'(g))     bytes[g] <= rdata;
    end
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import cr_pkg::*;
#(
  parameter logic [15:0] SP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_target,
  input  logic [4:0]  req_index,
  input  logic [15:0] req_pair,
  input  logic [15:0] pc_in,
  input  logic [7:0]  psw_in,
  input  logic        nmi_enter,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [15:0] pc_out,
  output logic        pc_load,
  output logic [15:0] sp_out,
  output logic [7:0]  psw_out,
  output logic        psw_load,
  output logic [15:0] pair_out,
  output logic        pair_load,
  output logic        nmi_flag
);
  cr_op_e              req_e, op_q;
  logic                accept, commit;
  logic [STEP_W-1:0]   step;
  logic [AW-1:0]       sp_q, word_q, target_q, vec_q, pc_q, pair_q;
  logic [BW-1:0]       psw_in_q, psw_q;
  logic                nmi_q;
  logic [1:0]          rd_slot;
  logic [2:0][BW-1:0]  rd_bytes;
  logic [AW-1:0]       popped_word;

  assign req_e       = cr_op_e'(req_op);
  assign accept      = req_valid && !busy;
  assign popped_word = {rd_bytes[1], rd_bytes[0]};

  cr_sched u_sched (
    .clk(clk), .rst_n(rst_n), .start(accept), .n_in(op_cycles(req_e)),
    .busy(busy), .step(step), .commit(commit), .done(done)
  );

  cr_access u_access (
    .busy(busy), .op(op_q), .step(step), .sp(sp_q), .word(word_q),
    .psw(psw_in_q), .vec(vec_q), .rd(mem_rd), .wr(mem_wr),
    .addr(mem_addr), .wdata(mem_wdata), .slot(rd_slot)
  );

  cr_rdbuf #(.SLOTS(3)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .rd(mem_rd), .slot(rd_slot),
    .rdata(mem_rdata), .bytes(rd_bytes)
  );

  // Operand capture at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_CALL;
      word_q   <= '0;
      target_q <= '0;
      vec_q    <= VEC_BASE;
      psw_in_q <= '0;
    end else if (accept) begin
      op_q     <= req_e;
      word_q   <= (req_e == OP_PUSHP) ? req_pair : return_pc(req_e, pc_in);
      target_q <= req_target;
      vec_q    <= vector_addr(req_index);
      psw_in_q <= psw_in;
    end
  end

  // Architectural results, committed one cycle before done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_INIT;
      pc_q   <= '0;
      psw_q  <= '0;
      pair_q <= '0;
    end else if (commit) begin
      sp_q <= sp_after(op_q, sp_q);
      case (op_q)
        OP_CALL:         pc_q <= target_q;
        OP_CALLT,
        OP_RET:          pc_q <= popped_word;
        OP_RETI: begin
          pc_q  <= popped_word;
          psw_q <= rd_bytes[2];
        end
        OP_POPF:         psw_q  <= rd_bytes[0];
        OP_POPP:         pair_q <= popped_word;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          nmi_q <= 1'b0;
    else if (commit && op_q == OP_RETI)  nmi_q <= 1'b0;
    else if (nmi_enter)                  nmi_q <= 1'b1;
  end

  assign sp_out    = sp_q;
  assign pc_out    = pc_q;
  assign psw_out   = psw_q;
  assign pair_out  = pair_q;
  assign nmi_flag  = nmi_q;
  assign pc_load   = done && (op_q inside {OP_CALL, OP_CALLT, OP_RET, OP_RETI});
  assign psw_load  = done && (op_q inside {OP_RETI, OP_POPF});
  assign pair_load = done && (op_q == OP_POPP);

  // R4: one access per cycle, only during an operation
  a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r4_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);
  // R6: vector fetches stay in the low-memory table
  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && op_q == OP_CALLT) |-> (mem_addr >= 16'h0040 && mem_addr <= 16'h007F));
  // R11: the stack pointer moves only on the commit step
  a_r11_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sp_q));
  // R8: return from interrupt leaves the servicing flag clear
  a_r8_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_q == OP_RETI) |=> !nmi_q);
  // R12: load strobes appear only with done
  a_r12_load_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load || psw_load || pair_load) |-> done);
endmodule

// File: tb/callret_seq_bench.sv
module callret_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_target = '0, req_pair = '0, pc_in = '0;
  logic [4:0]  req_index = '0;
  logic [7:0]  psw_in = '0;
  logic        nmi_enter = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, mem_rd, mem_wr, pc_load, psw_load, pair_load, nmi_flag;
  logic [15:0] mem_addr, pc_out, sp_out, pair_out;
  logic [7:0]  mem_wdata, psw_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  callret_seq u_callret_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_target(req_target), .req_index(req_index), .req_pair(req_pair),
    .pc_in(pc_in), .psw_in(psw_in), .nmi_enter(nmi_enter), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_out(pc_out), .pc_load(pc_load),
    .sp_out(sp_out), .psw_out(psw_out), .psw_load(psw_load), .pair_out(pair_out),
    .pair_load(pair_load), .nmi_flag(nmi_flag)
  );

  // Byte memory seen by the block.
  logic [7:0] mem [int];

  function automatic int peek(int a);
    int k = a & 16'hFFFF;
    return mem.exists(k) ? int'(mem[k]) : 0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= 8'(peek(int'(mem_addr)));
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  typedef struct { bit rd; bit wr; int addr; int data; } acc_t;

  int m_sp;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int tgt, input int idx, input int pair,
                        input int pc, input int psw, input bit spurious);
    acc_t q[$];
    int n, vec, ret, e_sp, e_pc, e_psw, e_pair;
    int budgets[8] = '{6, 8, 6, 8, 2, 4, 4, 6};
    string tag;
    n   = budgets[op];
    vec = 64 + 2 * idx;
    ret = (pc + ((op == 0) ? 3 : 1)) & 16'hFFFF;
    e_pc = -1; e_psw = -1; e_pair = -1;
    case (op)
      0, 1: begin
        tag = (op == 0) ? "R5" : "R6";
        q.push_back('{0, 1, (m_sp - 1) & 16'hFFFF, ret >> 8});
        q.push_back('{0, 1, (m_sp - 2) & 16'hFFFF, ret & 255});
        if (op == 1) begin
          q.push_back('{1, 0, vec, 0});
          q.push_back('{1, 0, vec + 1, 0});
          e_pc = peek(vec) | (peek(vec + 1) << 8);
        end else e_pc = tgt;
        e_sp = m_sp - 2;
      end
      2, 3: begin
        tag = (op == 2) ? "R7" : "R8";
        for (int i = 0; i < op; i++) q.push_back('{1, 0, (m_sp + i) & 16'hFFFF, 0});
        e_pc = peek(m_sp) | (peek(m_sp + 1) << 8);
        if (op == 3) e_psw = peek(m_sp + 2);
        e_sp = m_sp + op;
      end
      4: begin
        tag = "R9";
        q.push_back('{0, 1, (m_sp - 1) & 16'hFFFF, psw});
        e_sp = m_sp - 1;
      end
      5: begin
        tag = "R10";
        q.push_back('{0, 1, (m_sp - 1) & 16'hFFFF, pair >> 8});
        q.push_back('{0, 1, (m_sp - 2) & 16'hFFFF, pair & 255});
        e_sp = m_sp - 2;
      end
      6: begin
        tag = "R9";
        q.push_back('{1, 0, m_sp & 16'hFFFF, 0});
        e_psw = peek(m_sp);
        e_sp = m_sp + 1;
      end
      default: begin
        tag = "R10";
        q.push_back('{1, 0, m_sp & 16'hFFFF, 0});
        q.push_back('{1, 0, (m_sp + 1) & 16'hFFFF, 0});
        e_pair = peek(m_sp) | (peek(m_sp + 1) << 8);
        e_sp = m_sp + 2;
      end
    endcase
    e_sp = e_sp & 16'hFFFF;
    while (q.size() < n) q.push_back('{0, 0, -1, 0});

    @(negedge clk);
    req_op = 3'(op); req_target = 16'(tgt); req_index = 5'(idx);
    req_pair = 16'(pair); pc_in = 16'(pc); psw_in = 8'(psw); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(mem_rd == q[k].rd && mem_wr == q[k].wr, tag, $sformatf("strobes step %0d (R4)", k),
          {mem_rd, mem_wr}, {q[k].rd, q[k].wr});
      if (q[k].rd || q[k].wr)
        chk(int'(mem_addr) == q[k].addr, tag, $sformatf("address step %0d (R11)", k),
            mem_addr, q[k].addr);
      if (q[k].wr)
        chk(int'(mem_wdata) == q[k].data, tag, $sformatf("wdata step %0d", k),
            mem_wdata, q[k].data);
      chk(done == (k == n - 1), "R3", $sformatf("done step %0d op %0d", k, op), done, k == n - 1);
      if (k == n - 1) begin
        chk(int'(sp_out) == e_sp, tag, "sp (R11)", sp_out, e_sp);
        chk(pc_load == (op <= 3), "R12", "pc_load", pc_load, op <= 3);
        chk(psw_load == (op == 3 || op == 6), "R12", "psw_load", psw_load, op == 3 || op == 6);
        chk(pair_load == (op == 7), "R12", "pair_load", pair_load, op == 7);
        if (e_pc >= 0)   chk(int'(pc_out) == e_pc, tag, "pc", pc_out, e_pc);
        if (e_psw >= 0)  chk(int'(psw_out) == e_psw, tag, "psw", psw_out, e_psw);
        if (e_pair >= 0) chk(int'(pair_out) == e_pair, tag, "pair", pair_out, e_pair);
      end
      if (spurious && k == 1) begin
        req_op = 3'd6; req_valid = 1'b1;
      end
      if (spurious && k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(!busy && !done && !mem_rd && !mem_wr, "R2", "idle after done",
        {busy, done, mem_rd, mem_wr}, 0);
    m_sp = e_sp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL R3 watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    mem[16'h004A] = 8'h56; mem[16'h004B] = 8'h34;
    mem[16'h007E] = 8'hCD; mem[16'h007F] = 8'hAB;
    mem[16'h0000] = 8'h9C;
    m_sp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sp_out == 16'h0000, "R1", "sp reset", sp_out, 0);
    chk(!done && !busy && !mem_rd && !mem_wr, "R1", "control reset",
        {done, busy, mem_rd, mem_wr}, 0);
    chk(!pc_load && !psw_load && !pair_load && !nmi_flag, "R1", "strobes reset",
        {pc_load, psw_load, pair_load, nmi_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(5, 0, 0, 16'h1234, 0, 0, 0);          // R10 push pair, R11 wrap down
    run_op(4, 0, 0, 0, 0, 8'hA5, 0);             // R9 push status
    run_op(0, 16'h2000, 0, 0, 16'h0100, 0, 1);   // R5 call, R2 request while busy
    run_op(1, 0, 5, 0, 16'h2000, 0, 0);          // R6 table call
    run_op(1, 0, 31, 0, 16'h3456, 0, 1);         // R6 last vector, R2
    run_op(2, 0, 0, 0, 0, 0, 0);                 // R7 return
    run_op(2, 0, 0, 0, 0, 0, 0);
    run_op(2, 0, 0, 0, 0, 0, 0);
    run_op(6, 0, 0, 0, 0, 0, 0);                 // R9 pop status
    run_op(7, 0, 0, 0, 0, 0, 0);                 // R10 pop pair, R11 wrap up
    run_op(4, 0, 0, 0, 0, 8'h77, 0);
    run_op(7, 0, 0, 0, 0, 0, 0);                 // R11 pop across FFFF->0000
    // R8: set the servicing flag, build a frame, return from interrupt
    nmi_enter = 1'b1;
    @(negedge clk);
    nmi_enter = 1'b0;
    chk(nmi_flag == 1'b1, "R8", "nmi flag set", nmi_flag, 1);
    run_op(4, 0, 0, 0, 0, 8'h5A, 0);
    run_op(5, 0, 0, 16'h4000, 0, 0, 0);
    run_op(3, 0, 0, 0, 0, 0, 1);
    chk(nmi_flag == 1'b0, "R8", "nmi flag cleared", nmi_flag, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule